// File: doc/BRIEF.md
# Multi-port GPIO pin controller

This block is a register-mapped controller for general purpose pins, grouped into ports of eight pins each, with up to seven ports. Software reaches it over a simple 32-bit register bus. There are separate write and read strobes, and read data returns one cycle after the read strobe. Each pin has a two-bit drive mode, an output data bit and a pull-up control bit. Each pin also has a synchronised input level that software can read back.

The block turns each pin's mode and data bit into the three pad-level signals: drive level, output enable and pull-up enable. Beside these it supplies push-pull, open-drain and open-source drive. A global control register holds two writable enable bits. It also reports a core version and the number of fitted ports, so software can work out the pin count. Edge interrupt detection lives in a separate block.

Top module: `gpio_pinctrl`

## Requirements
- R1: Port n occupies the byte window starting at n*0x30. Inside a port, the synchronised input register is at +0x04, output data at +0x08, pin modes at +0x0C and pull-up control at +0x10. The global control register is at address 0x00. Read data appears on `busRdata` one clock after the edge that samples `busRead`.
- R2: After reset, every mode, output-data and pull-up register is zero, and both control enable bits are zero. As a result `padOe` is all zeros, `padOut` is all zeros and `padPullEn` is all ones.
- R3: The mode register keeps pin k's mode in bits 2k+1:2k. Only bits 15:0 are stored, and bits 31:16 read as zero. The codes are 00 input, 01 push-pull, 10 open-drain and 11 open-source.
- R4: A push-pull pin (01) has its output enable set, and its pad level equals its data bit.
- R5: An open-drain pin (10) with data 0 drives low with output enable set. With data 1 its output enable is clear and the pad level is 0.
- R6: An open-source pin (11) with data 1 drives high with output enable set. With data 0 its output enable is clear and the pad level is 1.
- R7: An input pin (00) has its output enable clear and pad level 0, whatever its data bit is.
- R8: In the pull-up register a 1 in bit k disables pin k's pull-up (`padPullEn` low) and a 0 enables it. Only bits 7:0 are stored, and the rest read as zero.
- R9: The input register returns pad levels through two flip-flops. A read captured on the first or second clock edge after a pad change still returns the old level; the third returns the new one. Writes to the input register are ignored.
- R10: Control bits 1:0 are writable and read back. Bits 8:2 return the `CORE_VERSION` parameter and bits 15:9 return `NUM_PORTS`. Bits 31:16 read as zero, and writes leave the read-only fields unchanged.
- R11: Reads of unused offsets, misaligned addresses, offset 0x00 of any port other than port 0, or ports at or beyond `NUM_PORTS` return zero. Writes to any of these leave every pad output unchanged.
- R12: The output data register stores bits 7:0 and reads them back, with bits 31:8 reading as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe, sampled on the rising edge |
| busRead | input | 1 | Read strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| padIn | input | NUM_PORTS*8 | Pad input levels, asynchronous |
| padOut | output | NUM_PORTS*8 | Pad drive level |
| padOe | output | NUM_PORTS*8 | Pad output enable |
| padPullEn | output | NUM_PORTS*8 | Pad pull-up enable |

## Verification
The drive logic is exercised with whole ports set to one mode and driven with the alternating patterns 0xA5 and 0x00/0xFF. This separates data-following modes from data-inverting modes and from modes that float on a given bit. One port mixes all four codes across its pins, which catches swapped mode fields or a mis-positioned 2k bit pair. The input path is read at three successive edges after a pad change, which pins down the exact synchroniser depth. Writes to reserved, misaligned and out-of-range addresses are followed by a comparison of every pad output, which shows that these writes have no effect.

// File: rtl/gpio_pinctrl_pkg.sv
package gpio_pinctrl_pkg;

  localparam int PINS_PER_PORT = 8;
  localparam int PORT_SPAN     = 48;   // bytes per port window
  localparam int PORT_IDX_W    = 3;    // enough for seven ports

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_IN,
    SEL_OUT,
    SEL_CFG,
    SEL_PULL
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_IN = 2'b00,
    MODE_PP = 2'b01,
    MODE_OD = 2'b10,
    MODE_OS = 2'b11
  } pinMode_e;

  // Strobes handed from the decoder to the register datapath.
  typedef struct packed {
    logic                  wrCtrl;
    logic                  wrOut;
    logic                  wrCfg;
    logic                  wrPull;
    logic                  rdEn;
    regSel_e               sel;
    logic [PORT_IDX_W-1:0] port;
  } busStb_t;

endpackage

// File: rtl/gpio_pinctrl_ctrl.sv
module gpio_pinctrl_ctrl
  import gpio_pinctrl_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output busStb_t           stb
);

  localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(PORT_SPAN);
  localparam logic [ADDR_W-1:0] PORTS_A = ADDR_W'(NUM_PORTS);

  logic [ADDR_W-1:0] portIdx;
  logic [ADDR_W-1:0] portBase;
  logic [ADDR_W-1:0] offs;
  logic              inRange;
  regSel_e           sel;

  always_comb begin
    portIdx  = busAddr / SPAN_A;
    portBase = portIdx * SPAN_A;
    offs     = busAddr - portBase;
    inRange  = (portIdx < PORTS_A);
  end

  always_comb begin
    sel = SEL_NONE;
    if (busAddr == '0) begin
      sel = SEL_CTRL;
    end else if (inRange) begin
      case (offs)
        ADDR_W'(8'h04): sel = SEL_IN;
        ADDR_W'(8'h08): sel = SEL_OUT;
        ADDR_W'(8'h0C): sel = SEL_CFG;
        ADDR_W'(8'h10): sel = SEL_PULL;
        default:        sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb.wrCtrl = busWrite && (sel == SEL_CTRL);
    stb.wrOut  = busWrite && (sel == SEL_OUT);
    stb.wrCfg  = busWrite && (sel == SEL_CFG);
    stb.wrPull = busWrite && (sel == SEL_PULL);
    stb.rdEn   = busRead;
    stb.sel    = sel;
    stb.port   = portIdx[PORT_IDX_W-1:0];
  end

  // R1: at most one register is written per cycle
  assert_single_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtrl, stb.wrOut, stb.wrCfg, stb.wrPull}));

  // R11: writes beyond the fitted ports never reach a register
  assert_oob_write_dropped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && (busAddr >= ADDR_W'(NUM_PORTS * PORT_SPAN)))
      |-> !(stb.wrCtrl || stb.wrOut || stb.wrCfg || stb.wrPull));

endmodule

// File: rtl/gpio_pinctrl_pad.sv
module gpio_pinctrl_pad
  import gpio_pinctrl_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dataBit,
  output logic       oe,
  output logic       level
);

  always_comb begin
    unique case (pinMode_e'(mode))
      MODE_PP: begin oe = 1'b1;     level = dataBit; end
      MODE_OD: begin oe = ~dataBit; level = 1'b0;    end
      MODE_OS: begin oe = dataBit;  level = 1'b1;    end
      default: begin oe = 1'b0;     level = 1'b0;    end
    endcase
  end

endmodule

// File: rtl/gpio_pinctrl_dp.sv
module gpio_pinctrl_dp
  import gpio_pinctrl_pkg::*;
#(
  parameter int         NUM_PORTS    = 7,
  parameter logic [6:0] CORE_VERSION = 7'd5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  busStb_t                             stb,
  input  logic [31:0]                         busWdata,
  output logic [31:0]                         busRdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  padIn,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padOut,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padOe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padPullEn
);

  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;
  localparam int CFG_W    = 2 * PINS_PER_PORT;

  logic [1:0]                                ctrlBits;
  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0]   outReg;
  logic [NUM_PORTS-1:0][CFG_W-1:0]           cfgReg;
  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0]   pullReg;
  logic [NUM_PINS-1:0]                       syncA;
  logic [NUM_PINS-1:0]                       syncB;
  logic [31:0]                               rdNext;
  logic                                      unusedWdata;

  assign unusedWdata = ^busWdata[31:CFG_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlBits <= '0;
    else if (stb.wrCtrl) ctrlBits <= busWdata[1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = (stb.port == PORT_IDX_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg[p]  <= '0;
        cfgReg[p]  <= '0;
        pullReg[p] <= '0;
      end else if (hit) begin
        if (stb.wrOut)  outReg[p]  <= busWdata[PINS_PER_PORT-1:0];
        if (stb.wrCfg)  cfgReg[p]  <= busWdata[CFG_W-1:0];
        if (stb.wrPull) pullReg[p] <= busWdata[PINS_PER_PORT-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int PI = i / PINS_PER_PORT;
    localparam int BI = i % PINS_PER_PORT;
    gpio_pinctrl_pad u_pad (
      .mode    (cfgReg[PI][2*BI +: 2]),
      .dataBit (outReg[PI][BI]),
      .oe      (padOe[i]),
      .level   (padOut[i])
    );
    assign padPullEn[i] = ~pullReg[PI][BI];
  end

  always_comb begin
    rdNext = '0;
    if (stb.sel == SEL_CTRL) begin
      rdNext = {16'b0, 7'(NUM_PORTS), CORE_VERSION, ctrlBits};
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (stb.port == PORT_IDX_W'(p)) begin
          case (stb.sel)
            SEL_IN:   rdNext = 32'(syncB[p*PINS_PER_PORT +: PINS_PER_PORT]);
            SEL_OUT:  rdNext = 32'(outReg[p]);
            SEL_CFG:  rdNext = 32'(cfgReg[p]);
            SEL_PULL: rdNext = 32'(pullReg[p]);
            default:  rdNext = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdNext;
  end

  // Cycles since reset, saturating, for the synchroniser check.
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  // R9: the readable input level lags the pad by exactly two edges
  assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (syncB == $past(padIn, 2)));

  // R3: modes change only on a decoded mode write
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCfg |=> $stable(cfgReg));

  // R3: a mode write lands the low 16 data bits in the addressed port
  assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCfg && stb.port == '0) |=> (cfgReg[0] == $past(busWdata[CFG_W-1:0])));

  // R10: read-only identity fields are returned on every control read
  assert_ctrl_ident_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.sel == SEL_CTRL)
      |=> (busRdata[31:2] == {16'b0, 7'(NUM_PORTS), CORE_VERSION}));

endmodule

// File: rtl/gpio_pinctrl.sv
module gpio_pinctrl
  import gpio_pinctrl_pkg::*;
#(
  parameter int         NUM_PORTS    = 7,
  parameter int         ADDR_W       = 9,
  parameter logic [6:0] CORE_VERSION = 7'd5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                busWrite,
  input  logic                                busRead,
  input  logic [ADDR_W-1:0]                   busAddr,
  input  logic [31:0]                         busWdata,
  output logic [31:0]                         busRdata,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  padIn,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padOut,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padOe,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0]  padPullEn
);

  busStb_t stb;

  gpio_pinctrl_ctrl #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWrite (busWrite),
    .busRead  (busRead),
    .busAddr  (busAddr),
    .stb      (stb)
  );

  gpio_pinctrl_dp #(
    .NUM_PORTS    (NUM_PORTS),
    .CORE_VERSION (CORE_VERSION)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn)
  );

endmodule

// File: tb/gpio_pinctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pinctrl_tb_top;

  localparam int NP = 7;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busWrite = 1'b0;
  logic            busRead = 1'b0;
  logic [8:0]      busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NPIN-1:0] padIn = '0;
  logic [NPIN-1:0] padOut, padOe, padPullEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_pinctrl dut_i (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullEn(padPullEn)
  );

  // {port[3], mode[2], data[8], expected oe[8], expected level[8]}
  localparam logic [28:0] VECS [8] = '{
    {3'd0, 2'd1, 8'hA5, 8'hFF, 8'hA5},
    {3'd1, 2'd2, 8'hA5, 8'h5A, 8'h00},
    {3'd2, 2'd3, 8'hA5, 8'hA5, 8'hFF},
    {3'd3, 2'd0, 8'hFF, 8'h00, 8'h00},
    {3'd6, 2'd1, 8'h00, 8'hFF, 8'h00},
    {3'd6, 2'd2, 8'h00, 8'hFF, 8'h00},
    {3'd6, 2'd3, 8'h00, 8'h00, 8'hFF},
    {3'd4, 2'd2, 8'hFF, 8'h00, 8'h00}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input int addr, input logic [31:0] data);
    @(negedge clk);
    busWrite = 1'b1; busAddr = 9'(addr); busWdata = data;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input int addr, output logic [31:0] data);
    @(negedge clk);
    busRead = 1'b1; busAddr = 9'(addr);
    @(negedge clk);
    busRead = 1'b0;
    data = busRdata;
  endtask

  initial begin
    logic [31:0] rd;
    logic [NPIN-1:0] sOe, sOut, sPull;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 oe", 64'(padOe), 64'(0));
    check("R2 out", 64'(padOut), 64'(0));
    check("R2 pull", 64'(padPullEn), {8'h0, {NPIN{1'b1}}});
    busRd(2*48 + 12, rd); check("R2 cfg", 64'(rd), 64'(0));
    busRd(0, rd); check("R2 R10 ctrl", 64'(rd), 64'h0E14);

    // R4 R5 R6 R7 vector walk
    for (int v = 0; v < 8; v++) begin
      int p = int'(VECS[v][28:26]);
      busWr(p*48 + 12, {16'hFFFF, {8{VECS[v][25:24]}}});
      busWr(p*48 + 8, {24'hFFFFFF, VECS[v][23:16]});
      check($sformatf("R4 R5 R6 R7 oe vec%0d", v), 64'(padOe[p*8 +: 8]), 64'(VECS[v][15:8]));
      check($sformatf("R4 R5 R6 R7 out vec%0d", v), 64'(padOut[p*8 +: 8]), 64'(VECS[v][7:0]));
    end

    // R3 mixed modes on port 5, readback masked
    busWr(5*48 + 12, 32'hFFFF_E4E4);
    busWr(5*48 + 8, 32'h0000_000F);
    check("R3 oe mixed", 64'(padOe[40 +: 8]), 64'h6A);
    check("R3 out mixed", 64'(padOut[40 +: 8]), 64'h8A);
    busRd(5*48 + 12, rd); check("R3 cfg readback", 64'(rd), 64'h0000_E4E4);

    // R12 output data readback
    busWr(0*48 + 8, 32'hFFFF_FF5A);
    busRd(0*48 + 8, rd); check("R12 out readback", 64'(rd), 64'h5A);

    // R8 pull-up control
    busWr(1*48 + 16, 32'hFFFF_FF3C);
    check("R8 pull pads", 64'(padPullEn[8 +: 8]), 64'hC3);
    check("R8 other port", 64'(padPullEn[16 +: 8]), 64'hFF);
    busRd(1*48 + 16, rd); check("R8 pull readback", 64'(rd), 64'h3C);

    // R10 control register
    busWr(0, 32'hFFFF_FFFF);
    busRd(0, rd); check("R10 ctrl after write", 64'(rd), 64'h0E17);

    // R9 synchroniser depth
    @(negedge clk);
    padIn = {NPIN{1'b0}};
    repeat (3) @(negedge clk);
    padIn[24 +: 8] = 8'hC6;
    busRead = 1'b1; busAddr = 9'(3*48 + 4);
    @(negedge clk); check("R9 edge1 old", 64'(busRdata), 64'h00);
    @(negedge clk); check("R9 edge2 old", 64'(busRdata), 64'h00);
    @(negedge clk); check("R9 edge3 new", 64'(busRdata), 64'hC6);
    busRead = 1'b0;
    busWr(3*48 + 4, 32'h0000_0011);
    busRd(3*48 + 4, rd); check("R9 input write ignored", 64'(rd), 64'hC6);

    // R11 unused addresses
    sOe = padOe; sOut = padOut; sPull = padPullEn;
    busWr(7*48 + 8, 32'hFFFF_FFFF);
    busWr(7*48 + 12, 32'hFFFF_FFFF);
    busWr(1*48, 32'hFFFF_FFFF);
    busWr(11, 32'hFFFF_FFFF);
    busWr(2*48 + 20, 32'hFFFF_FFFF);
    check("R11 oe unchanged", 64'(padOe), 64'(sOe));
    check("R11 out unchanged", 64'(padOut), 64'(sOut));
    check("R11 pull unchanged", 64'(padPullEn), 64'(sPull));
    busRd(7*48 + 8, rd); check("R11 port7 read", 64'(rd), 64'(0));
    busRd(1*48, rd); check("R11 port1 off0 read", 64'(rd), 64'(0));
    busRd(11, rd); check("R11 misaligned read", 64'(rd), 64'(0));
    busRd(2*48 + 20, rd); check("R11 gap read", 64'(rd), 64'(0));

    // R1 window placement: port 6 out register distinct from port 5
    busWr(6*48 + 8, 32'h0000_0033);
    busRd(5*48 + 8, rd); check("R1 port5 out", 64'(rd), 64'h0F);
    busRd(6*48 + 8, rd); check("R1 port6 out", 64'(rd), 64'h33);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule